// File: doc/BRIEF.md
# Monitor-Mode Trace Trap Unit

This block gives a 24-bit processor a debug facility for code running in user mode. A three-bit monitor mode field picks what the unit watches. It can raise a trap on every instruction fetch, on every taken branch (and hold that branch back), or on every instruction that sets the overflow flag. A fourth choice records branch targets into a circular table in memory, and traps nothing. A no-op whose index field is 7 raises a trap in any active mode. While the executive flag is high, the unit takes no action at all.

Trap requests are stored in a sticky status bit. That bit stays high until the CPU's interrupt entry clears it. In branch-log mode, each taken branch starts three memory cycles. The unit reads a pointer word from a fixed address, stores the branch target at the address the pointer holds, and then writes the pointer back with its low seven bits advanced. The unit holds `busy_o` high through these three cycles so the CPU stalls until the log entry is in memory.

Top module: `trace_trap_unit`

## Requirements
- R1: After reset, `trap_o`, `busy_o` and `mem_req_o` are 0.
- R2: When `exec_mode_i` is 1, no event raises a trap, `suppress_o` stays 0 and no memory cycle starts, whatever the mode.
- R3: In mode 1 (`mon_mode_i`=3'd1), a cycle with `fetch_i`=1 makes `trap_o` 1 from the next cycle on.
- R4: In mode 3, a cycle with `branch_i`=1 drives `suppress_o`=1 in that same cycle (combinational) and makes `trap_o` 1 from the next cycle on.
- R5: In mode 4, a cycle with `ovf_set_i`=1 makes `trap_o` 1 from the next cycle on. This covers a branch-on-overflow-clear that flips the flag to 1, which the CPU reports on `ovf_set_i`.
- R6: In modes 1 to 4, a cycle with `noop_i`=1 and `noop_idx_i`=3'd7 makes `trap_o` 1 from the next cycle on. A no-op with any other index raises nothing.
- R7: Modes 0, 5, 6 and 7 produce no trap, no suppress and no memory cycle for any event.
- R8: `trap_o` is sticky. It stays 1 while `trap_clr_i` is 0, and it drops one cycle after `trap_clr_i` is 1. A new trap event in the same cycle as a clear wins, so `trap_o` stays 1.
- R9: In mode 2, a branch causes three memory cycles. The first reads the word at `PTR_ADDR` (default 262). The second writes the branch target, zero-extended, to the low `AW` bits of the pointer. The third writes the pointer back to `PTR_ADDR` with bits [6:0] incremented modulo 128 and the upper bits unchanged. The branch is not suppressed and no trap is raised.
- R10: `busy_o` is 1 from the cycle after the branch until the ack of the third memory cycle. A branch that arrives while `busy_o` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_mode_i | input | 1 | Executive mode flag; 1 disables monitoring |
| mon_mode_i | input | 3 | Monitor mode field |
| fetch_i | input | 1 | Instruction fetch strobe |
| branch_i | input | 1 | A branch would be taken this cycle |
| target_i | input | AW (22) | Branch target address |
| ovf_set_i | input | 1 | An instruction sets the overflow flag |
| noop_i | input | 1 | A no-op instruction executes |
| noop_idx_i | input | 3 | Index field of the no-op |
| trap_clr_i | input | 1 | Clears the sticky trap bit |
| trap_o | output | 1 | Sticky trap request |
| suppress_o | output | 1 | Holds back the current branch |
| busy_o | output | 1 | Log sequence in progress; CPU stalls |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | AW (22) | Memory address |
| mem_wdata_o | output | DW (24) | Write data |
| mem_rdata_i | input | DW (24) | Read data, valid with ack |
| mem_ack_i | input | 1 | Completes the current memory cycle |

## Verification
`suppress_o` is combinational, so the bench samples it 1 ns after driving inputs at the falling edge. A trap request is registered once, so the bench expects `trap_o` at the next falling edge. During random runs the bench holds `trap_clr_i` high, which makes `trap_o` follow the previous cycle's event alone. Each log access in the bench memory model takes a request cycle plus an ack cycle. The bench therefore waits for `busy_o` to fall, within a bound, before it compares the memory contents.

// File: rtl/trace_trap_pkg.sv
package trace_trap_pkg;
  typedef enum logic [2:0] {
    MON_OFF   = 3'd0,
    MON_FETCH = 3'd1,
    MON_LOG   = 3'd2,
    MON_BRTRP = 3'd3,
    MON_OVF   = 3'd4
  } mon_mode_e;

  typedef enum logic [1:0] {
    LOG_IDLE = 2'd0,
    LOG_RDP  = 2'd1,
    LOG_WENT = 2'd2,
    LOG_WPTR = 2'd3
  } log_state_e;
endpackage

// File: rtl/trace_event_decode.sv
module trace_event_decode
  import trace_trap_pkg::*;
#(
  parameter int NOOP_W   = 3,
  parameter int NOOP_HIT = 7
) (
  input  logic              exec_mode_i,
  input  logic [2:0]        mon_mode_i,
  input  logic              fetch_i,
  input  logic              branch_i,
  input  logic              ovf_set_i,
  input  logic              noop_i,
  input  logic [NOOP_W-1:0] noop_idx_i,
  output logic              trap_evt_o,
  output logic              suppress_o,
  output logic              log_evt_o
);
  logic user_act;
  logic mode_live;

  always_comb begin
    user_act   = !exec_mode_i;
    mode_live  = (mon_mode_i >= 3'd1) && (mon_mode_i <= 3'd4);
    suppress_o = user_act && (mon_mode_i == MON_BRTRP) && branch_i;
    log_evt_o  = user_act && (mon_mode_i == MON_LOG) && branch_i;
    trap_evt_o = 1'b0;
    if (user_act) begin
      unique case (mon_mode_i)
        MON_FETCH: trap_evt_o = fetch_i;
        MON_BRTRP: trap_evt_o = branch_i;
        MON_OVF:   trap_evt_o = ovf_set_i;
        default:   trap_evt_o = 1'b0;
      endcase
      if (mode_live && noop_i && (noop_idx_i == NOOP_W'(NOOP_HIT)))
        trap_evt_o = 1'b1;
    end
  end
endmodule

// File: rtl/branch_log_seq.sv
module branch_log_seq
  import trace_trap_pkg::*;
#(
  parameter int AW       = 22,
  parameter int DW       = 24,
  parameter int IDX_W    = 7,
  parameter int PTR_ADDR = 262
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] target_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i
);
  localparam logic [AW-1:0] PTR_A = AW'(PTR_ADDR);

  log_state_e    st_q, st_d;
  logic [DW-1:0] ptr_q, ptr_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic [DW-1:0] ptr_next;

  always_comb begin
    ptr_next = {ptr_q[DW-1:IDX_W], IDX_W'(ptr_q[IDX_W-1:0] + 1'b1)};
    st_d  = st_q;
    ptr_d = ptr_q;
    tgt_d = tgt_q;
    unique case (st_q)
      LOG_IDLE: if (start_i) begin
        st_d  = LOG_RDP;
        tgt_d = target_i;
      end
      LOG_RDP: if (mem_ack_i) begin
        st_d  = LOG_WENT;
        ptr_d = mem_rdata_i;
      end
      LOG_WENT: if (mem_ack_i) st_d = LOG_WPTR;
      LOG_WPTR: if (mem_ack_i) st_d = LOG_IDLE;
      default:  st_d = LOG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LOG_IDLE;
      ptr_q <= '0;
      tgt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == LOG_RDP && mem_ack_i) ptr_q <= ptr_d;
      if (st_q == LOG_IDLE && start_i)  tgt_q <= tgt_d;
    end
  end

  always_comb begin
    busy_o      = (st_q != LOG_IDLE);
    mem_req_o   = busy_o;
    mem_we_o    = (st_q == LOG_WENT) || (st_q == LOG_WPTR);
    mem_addr_o  = PTR_A;
    mem_wdata_o = '0;
    if (st_q == LOG_WENT) begin
      mem_addr_o  = ptr_q[AW-1:0];
      mem_wdata_o = DW'(tgt_q);
    end else if (st_q == LOG_WPTR) begin
      mem_wdata_o = ptr_next;
    end
  end

  // R9
  first_access_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (mem_req_o && !mem_we_o && mem_addr_o == PTR_A));
  // R10
  seq_ends_after_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LOG_WPTR && mem_ack_i) |=> !busy_o);
  // R10
  req_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);
endmodule

// File: rtl/trace_trap_unit.sv
module trace_trap_unit
  import trace_trap_pkg::*;
#(
  parameter int AW       = 22,
  parameter int DW       = 24,
  parameter int NOOP_W   = 3,
  parameter int IDX_W    = 7,
  parameter int PTR_ADDR = 262
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_mode_i,
  input  logic [2:0]        mon_mode_i,
  input  logic              fetch_i,
  input  logic              branch_i,
  input  logic [AW-1:0]     target_i,
  input  logic              ovf_set_i,
  input  logic              noop_i,
  input  logic [NOOP_W-1:0] noop_idx_i,
  input  logic              trap_clr_i,
  output logic              trap_o,
  output logic              suppress_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_ack_i
);
  logic trap_evt, log_evt, log_start;
  logic trap_q, trap_d;

  trace_event_decode #(.NOOP_W(NOOP_W), .NOOP_HIT(7)) u_decode (
    .exec_mode_i (exec_mode_i),
    .mon_mode_i  (mon_mode_i),
    .fetch_i     (fetch_i),
    .branch_i    (branch_i),
    .ovf_set_i   (ovf_set_i),
    .noop_i      (noop_i),
    .noop_idx_i  (noop_idx_i),
    .trap_evt_o  (trap_evt),
    .suppress_o  (suppress_o),
    .log_evt_o   (log_evt)
  );

  assign log_start = log_evt && !busy_o;

  branch_log_seq #(.AW(AW), .DW(DW), .IDX_W(IDX_W), .PTR_ADDR(PTR_ADDR)) u_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (log_start),
    .target_i    (target_i),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i)
  );

  always_comb trap_d = trap_evt | (trap_q & !trap_clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end

  assign trap_o = trap_q;

  // R3
  trap_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_evt |=> trap_o);
  // R2
  exec_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_mode_i |-> (!trap_evt && !suppress_o && !log_start));
  // R8
  trap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o && !trap_clr_i) |=> trap_o);
  // R9
  log_no_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_evt |-> (!suppress_o && !trap_evt));
endmodule

// File: tb/trace_trap_unit_bench.sv
module trace_trap_unit_bench;
  localparam int AW = 22;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exec_mode, fetch, branch, ovf, noop, clr;
  logic [2:0] mode, nidx;
  logic [AW-1:0] target;
  logic trap, suppress, busy, mreq, mwe, mack;
  logic [AW-1:0] maddr;
  logic [DW-1:0] mwdata, mrdata;
  logic [DW-1:0] mem [512];
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  trace_trap_unit u_trace_trap_unit (
    .clk(clk), .rst_n(rst_n), .exec_mode_i(exec_mode), .mon_mode_i(mode),
    .fetch_i(fetch), .branch_i(branch), .target_i(target), .ovf_set_i(ovf),
    .noop_i(noop), .noop_idx_i(nidx), .trap_clr_i(clr), .trap_o(trap),
    .suppress_o(suppress), .busy_o(busy), .mem_req_o(mreq), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata),
    .mem_ack_i(mack)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mack   <= 1'b0;
      mrdata <= '0;
    end else begin
      mack   <= mreq & !mack;
      mrdata <= mem[maddr[8:0]];
      if (mreq && !mack && mwe) mem[maddr[8:0]] <= mwdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_trap(input logic ex, input logic [2:0] m,
      input logic f, input logic b, input logic o, input logic n, input logic [2:0] ix);
    logic t;
    if (ex || m == 0 || m > 4) return 1'b0;
    t = (n && ix == 3'd7);
    if (m == 1 && f) t = 1'b1;
    if (m == 3 && b) t = 1'b1;
    if (m == 4 && o) t = 1'b1;
    return t;
  endfunction

  task automatic idle_inputs();
    exec_mode = 0; mode = 0; fetch = 0; branch = 0; ovf = 0; noop = 0;
    nidx = 0; target = '0; clr = 1;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk("R10 busy drops", {31'd0, busy}, 0);
  endtask

  initial begin
    logic et;
    logic was_busy;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    idle_inputs();
    #9 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 trap", {31'd0, trap}, 0);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 req", {31'd0, mreq}, 0);

    // directed: mode 3 suppress and trap
    mode = 3; branch = 1;
    #1 chk("R4 suppress", {31'd0, suppress}, 1);
    @(negedge clk);
    branch = 0;
    chk("R4 trap", {31'd0, trap}, 1);
    // R8: sticky hold, then clear
    clr = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 sticky", {31'd0, trap}, 1);
    clr = 1;
    @(negedge clk);
    chk("R8 cleared", {31'd0, trap}, 0);
    // R8: set wins over clear
    mode = 1; fetch = 1; clr = 1;
    @(negedge clk);
    fetch = 0;
    chk("R8 set wins", {31'd0, trap}, 1);
    // R2: exec mode, mode 2 branch starts nothing
    exec_mode = 1; mode = 2; branch = 1;
    @(negedge clk);
    branch = 0;
    chk("R2 no log", {31'd0, busy}, 0);
    exec_mode = 0;
    @(negedge clk);

    // R9: log with wrapping index
    mem[262] = 24'hABC07F;
    mode = 2; branch = 1; target = 22'h012345;
    #1 chk("R9 no suppress", {31'd0, suppress}, 0);
    @(negedge clk);
    chk("R10 busy", {31'd0, busy}, 1);
    target = 22'h000111; // R10: ignored while busy
    @(negedge clk);
    branch = 0;
    wait_idle();
    chk("R9 entry", {8'd0, mem[9'h07F]}, 32'h012345);
    chk("R9 ptr wrap", {8'd0, mem[262]}, 32'hABC000);
    chk("R9 no trap", {31'd0, trap}, 0);
    // second entry, ptr low 0
    branch = 1; target = 22'h3FFFFF;
    @(negedge clk);
    branch = 0;
    wait_idle();
    chk("R9 entry2", {8'd0, mem[9'h000]}, 32'h3FFFFF);
    chk("R9 ptr inc", {8'd0, mem[262]}, 32'hABC001);

    // random, with mode 2 branches excluded
    idle_inputs();
    @(negedge clk);
    et = 1'b0;
    void'($urandom(32'h5EED));
    for (int k = 0; k < 2000; k++) begin
      chk("R3 R5 R6 R7 trap", {31'd0, trap}, {31'd0, et});
      exec_mode = ($urandom % 4) == 0;
      mode   = 3'($urandom);
      fetch  = 1'($urandom);
      branch = 1'($urandom);
      ovf    = 1'($urandom);
      noop   = 1'($urandom);
      nidx   = ($urandom % 2) ? 3'd7 : 3'($urandom);
      if (mode == 2) branch = 0;
      et = exp_trap(exec_mode, mode, fetch, branch, ovf, noop, nidx);
      #1 chk("R2 R4 R7 suppress", {31'd0, suppress},
             {31'd0, !exec_mode && mode == 3 && branch});
      was_busy = busy | mreq;
      chk("R2 R7 no mem", {31'd0, was_busy}, 0);
      @(negedge clk);
    end
    idle_inputs();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule